// File: doc/BRIEF.md
# Pulse-Signalled Bus Ownership Arbiter

This block hands the local bus to up to two outside masters. Each outside master shares one active-low line with the block, and that line carries the whole ownership exchange as single-clock low pulses. The outside master pulses once to ask for the bus. The block pulses once on the same line to hand the bus over. The outside master pulses a third time to give the bus back. Each line is modelled as three signals: an input copy, an output value and an output enable. When nothing drives a line it stays high.

The block watches the local bus-cycle engine through three inputs: its current clock state, a flag marking the first interrupt-acknowledge cycle, and a lock flag. From these it decides on which clock a grant may go out. While an outside master owns the bus, the block raises `bus_float` so that the local pads release the bus. After every return of the bus it forces one idle clock before it can issue a new grant. Channel 0 always wins over channel 1.

The controller has three states. LOCAL means the local side owns the bus and pending requests are arbitrated. LENT means an outside master owns the bus. GAP is the single idle clock after a return. The transitions are:
- LOCAL to LENT on a grant.
- LENT to GAP on a release pulse from the owning channel.
- GAP to LOCAL unconditionally.

Top module: `rgl_arbiter`

## Requirements
- R1: While reset is held, and right after it, no line is driven (`rq_oe` = 0, `rq_out` all ones), `bus_float` is 0 and no request is pending.
- R2: A low level on a line, sampled at a clock edge, records a request for that channel when the channel does not own the bus. The grant never appears in the clock of the request pulse itself.
- R3: A grant is a low on `rq_out[i]` with `rq_oe[i]` = 1 for exactly one clock. `bus_float` rises on the next clock and stays high until the release is taken.
- R4: `t_state` encoding: 0 = idle, 1 = T1, 2 = T2, 3 = T3, 4 = T4, 5 = wait. A grant may go out in states 0 and 1. In state 4 it may go out only if the request was captured in state 0, 1 or 2 and `first_inta` is low. It never goes out in states 2, 3 or 5.
- R5: While `lock` is high, no grant is issued. The request stays pending and is granted at a later permitted clock.
- R6: A low pulse on the owning channel's line while `bus_float` is high is a release, and `bus_float` falls on the next clock.
- R7: The clock right after a release is an idle clock. No grant is issued in it, even if a request is pending and the state permits one.
- R8: When both channels are pending, only channel 0 is granted.
- R9: A request from a channel that is not being served stays pending through the other channel's whole exchange, including requests pulsed while the other channel owns the bus. It is granted on the first permitted clock after the idle clock.
- R10: At most one `rq_oe` bit is high at any time, and only on a grant clock. A line that is not driven reads `rq_out` = 1.
- R11: The release pulse is not recorded as a new request from the channel that gave the bus back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rq_in | input | 2 | Sampled level of each shared line, active low |
| rq_out | output | 2 | Value driven onto each line while enabled |
| rq_oe | output | 2 | Output enable of each line, high only on a grant clock |
| t_state | input | 3 | Clock state of the local bus cycle (encoding in R4) |
| first_inta | input | 1 | High during the first interrupt-acknowledge cycle |
| lock | input | 1 | High while a locked sequence runs |
| bus_float | output | 1 | High while an outside master owns the bus |
| owner_ch | output | 1 | Channel that holds the bus while `bus_float` is high |

## Verification
A request pulse is registered at the clock edge that samples it. The grant is a combinational output of that registered request together with the current `t_state`, `first_inta` and `lock`, so it shows up in the next clock period, before that period's edge. `bus_float` rises one clock after the grant and falls one clock after the release. The following clock is always the idle one. The bench changes inputs on the falling edge and samples outputs 1 ns later, so each check reads the clock period whose inputs it has just set. A sweep covers every capture state against every decision state, with `first_inta` and `lock` at both values. Directed sequences then follow full exchanges clock by clock.

// File: rtl/rgl_pkg.sv
package rgl_pkg;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_T4   = 3'd4,
        TS_WAIT = 3'd5
    } tstate_e;

    typedef enum logic [1:0] {
        ST_LOCAL = 2'd0,
        ST_LENT  = 2'd1,
        ST_GAP   = 2'd2
    } own_e;

endpackage

// File: rtl/rgl_grant_window.sv
module rgl_grant_window
    import rgl_pkg::*;
#(
    parameter int TSW = 3
) (
    input  logic [TSW-1:0] t_state,
    input  logic           req_early,
    input  logic           first_inta,
    input  logic           lock,
    output logic           permit,
    output logic           early_now
);

    tstate_e ts;

    always_comb begin
        ts = tstate_e'(t_state[2:0]);
        early_now = (ts == TS_IDLE) || (ts == TS_T1) || (ts == TS_T2);
        permit = 1'b0;
        if (!lock) begin
            unique case (ts)
                TS_IDLE, TS_T1: permit = 1'b1;
                TS_T4:          permit = req_early && !first_inta;
                default:        permit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rgl_req_catch.sv
module rgl_req_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic line_low,
    input  logic cap_en,
    input  logic is_early,
    input  logic clear,
    output logic pend_o,
    output logic early_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o  <= 1'b0;
            early_o <= 1'b0;
        end else if (clear) begin
            pend_o  <= 1'b0;
            early_o <= 1'b0;
        end else if (line_low && cap_en && !pend_o) begin
            pend_o  <= 1'b1;
            early_o <= is_early;
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_low && cap_en && !clear) |=> pend_o);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pend_o);

endmodule

// File: rtl/rgl_arbiter.sv
module rgl_arbiter
    import rgl_pkg::*;
#(
    parameter int NCH = 2,
    parameter int TSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] rq_in,
    output logic [NCH-1:0] rq_out,
    output logic [NCH-1:0] rq_oe,
    input  logic [TSW-1:0] t_state,
    input  logic           first_inta,
    input  logic           lock,
    output logic           bus_float,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] owner_ch
);

    localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1;

    own_e           state_q, state_d;
    logic [IDW-1:0] owner_q, owner_d;
    logic [NCH-1:0] line_low, pend, early, permit, early_now, cap_en, grant_vec;
    logic [IDW-1:0] sel;
    logic           sel_ok;

    assign line_low = ~rq_in;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        rgl_grant_window #(.TSW(TSW)) u_win (
            .t_state   (t_state),
            .req_early (early[gi]),
            .first_inta(first_inta),
            .lock      (lock),
            .permit    (permit[gi]),
            .early_now (early_now[gi])
        );

        assign cap_en[gi] = !((state_q == ST_LENT) && (owner_q == IDW'(gi))) && !grant_vec[gi];

        rgl_req_catch u_catch (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_low(line_low[gi]),
            .cap_en  (cap_en[gi]),
            .is_early(early_now[gi]),
            .clear   (grant_vec[gi]),
            .pend_o  (pend[gi]),
            .early_o (early[gi])
        );
    end

    // fixed priority: lowest index wins
    always_comb begin
        sel    = '0;
        sel_ok = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                sel    = IDW'(i);
                sel_ok = 1'b1;
            end
        end
        grant_vec = '0;
        if ((state_q == ST_LOCAL) && sel_ok && permit[sel])
            grant_vec[sel] = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ST_LOCAL: begin
                if (|grant_vec) begin
                    state_d = ST_LENT;
                    owner_d = sel;
                end
            end
            ST_LENT: begin
                if (line_low[owner_q])
                    state_d = ST_GAP;
            end
            ST_GAP:  state_d = ST_LOCAL;
            default: state_d = ST_LOCAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCAL;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        rq_oe     = grant_vec;
        rq_out    = ~grant_vec;
        bus_float = (state_q == ST_LENT);
        owner_ch  = owner_q;
    end

    assert_oe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rq_oe));

    assert_float_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_oe) |=> bus_float);

    assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_oe) |-> ((t_state == 3'd0) || (t_state == 3'd1) || (t_state == 3'd4)));

    assert_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (rq_oe == '0));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_float && !rq_in[owner_ch]) |=> !bus_float);

    assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_float) |-> (rq_oe == '0));

    assert_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rq_oe) && pend[0]) |-> rq_oe[0]);

endmodule

// File: tb/tb_rgl_arbiter.sv
`timescale 1ns/1ps
module tb_rgl_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rq_in = 2'b11;
    logic [1:0] rq_out, rq_oe;
    logic [2:0] t_state = 3'd0;
    logic       first_inta = 1'b0;
    logic       lock = 1'b0;
    logic       bus_float;
    logic [0:0] owner_ch;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rgl_arbiter dut (
        .clk(clk), .rst_n(rst_n), .rq_in(rq_in), .rq_out(rq_out), .rq_oe(rq_oe),
        .t_state(t_state), .first_inta(first_inta), .lock(lock),
        .bus_float(bus_float), .owner_ch(owner_ch)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // set inputs just after a falling edge, then sample 1 ns later
    task automatic cyc(input logic [1:0] lines, input logic [2:0] ts,
                       input logic ia, input logic lk);
        rq_in = lines; t_state = ts; first_inta = ia; lock = lk;
        #1;
    endtask

    task automatic adv;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rq_in = 2'b11; t_state = 3'd0; first_inta = 1'b0; lock = 1'b0;
        rst_n = 1'b0;
        adv; adv;
        rst_n = 1'b1;
        adv;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: state while held in reset
        #1;
        check("R1 oe in reset", {6'd0, rq_oe}, 8'h00);
        check("R1 out in reset", {6'd0, rq_out}, 8'h03);
        check("R1 float in reset", {7'd0, bus_float}, 8'h00);
        do_reset;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R1 no grant after reset", {6'd0, rq_oe}, 8'h00);
        adv;

        // Sweep: capture state x decision state x first_inta x lock (R4, R5, R2)
        for (int cap = 0; cap < 6; cap++) begin
            for (int dec = 0; dec < 6; dec++) begin
                for (int ia = 0; ia < 2; ia++) begin
                    for (int lk = 0; lk < 2; lk++) begin
                        logic exp_g;
                        logic erly;
                        do_reset;
                        cyc(2'b10, 3'(cap), 1'b0, 1'b0);
                        check("R2 no grant in request clock", {6'd0, rq_oe}, 8'h00);
                        adv;
                        erly  = (cap <= 2);
                        exp_g = !lk && ((dec == 0) || (dec == 1) ||
                                        ((dec == 4) && erly && !ia));
                        cyc(2'b11, 3'(dec), 1'(ia), 1'(lk));
                        check(lk ? "R5 grant window under lock" : "R4 grant window",
                              {6'd0, rq_oe}, {6'd0, 1'b0, exp_g});
                        check("R10 undriven line high", {6'd0, rq_out}, {6'd0, 1'b1, !exp_g});
                        adv;
                    end
                end
            end
        end

        // Both channels together: priority, gap, pending carry-over
        do_reset;
        cyc(2'b00, 3'd0, 1'b0, 1'b0);
        check("R2 both pulse, no grant yet", {6'd0, rq_oe}, 8'h00);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R8 channel 0 wins", {6'd0, rq_oe}, 8'h01);
        check("R3 grant drives low", {6'd0, rq_out}, 8'h02);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R3 float after grant", {7'd0, bus_float}, 8'h01);
        check("R3 grant one clock", {6'd0, rq_oe}, 8'h00);
        check("R3 owner", {7'd0, owner_ch}, 8'h00);
        adv;
        cyc(2'b11, 3'd1, 1'b0, 1'b0);
        check("R9 ch1 waits while lent", {6'd0, rq_oe}, 8'h00);
        adv;
        cyc(2'b10, 3'd0, 1'b0, 1'b0);
        check("R6 float held in release clock", {7'd0, bus_float}, 8'h01);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R6 float dropped after release", {7'd0, bus_float}, 8'h00);
        check("R7 no grant in idle clock", {6'd0, rq_oe}, 8'h00);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R9 ch1 granted after gap", {6'd0, rq_oe}, 8'h02);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R3 float for ch1", {7'd0, bus_float}, 8'h01);
        check("R3 owner ch1", {7'd0, owner_ch}, 8'h01);
        adv;
        cyc(2'b01, 3'd0, 1'b0, 1'b0);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R7 idle clock after ch1", {6'd0, rq_oe}, 8'h00);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R11 release not a request", {6'd0, rq_oe}, 8'h00);
        adv;

        // Lock holds a request, then a request pulsed during ownership
        do_reset;
        cyc(2'b01, 3'd0, 1'b0, 1'b1);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b1);
        check("R5 no grant under lock", {6'd0, rq_oe}, 8'h00);
        adv;
        cyc(2'b11, 3'd1, 1'b0, 1'b1);
        check("R5 still held", {6'd0, rq_oe}, 8'h00);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R5 granted after lock drops", {6'd0, rq_oe}, 8'h02);
        adv;
        cyc(2'b10, 3'd0, 1'b0, 1'b0);
        check("R9 pulse during ownership no grant", {6'd0, rq_oe}, 8'h00);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R3 float holds", {7'd0, bus_float}, 8'h01);
        adv;
        cyc(2'b01, 3'd0, 1'b0, 1'b0);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R7 gap before ch0", {6'd0, rq_oe}, 8'h00);
        adv;
        cyc(2'b11, 3'd0, 1'b0, 1'b0);
        check("R9 ch0 request kept", {6'd0, rq_oe}, 8'h01);
        adv;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule